// File: doc/BRIEF.md
# Vertical Sync Source Selector with Programmable Delay

This block picks one vertical sync candidate out of a set of input signals, optionally flips its polarity, and then delays it by a programmable number of sample clocks. The result is the filtered vertical sync that the downstream timing logic uses. The candidates are produced elsewhere: the dedicated vertical pin, a sync separated from composite sync, three sync-on-green comparators and an alternate sync-on-green path. The control values come from a register bank outside the block. That bank should reset the delay to 0x080.

The delay reproduces each rising and each falling edge exactly the programmed number of clocks later. It does this by storing a timestamp for each pending transition rather than shifting the waveform through a 4095-stage line. A small queue holds the pending transitions. Any transition that arrives while the queue is full is discarded. A delay of zero bypasses the queue and gives a single register stage. Changing the select code flushes the queue.

Top module: `vsync_select_delay`

## Requirements
- R1: Select codes 0 to 5 route input bit `cand_vs[code]` to the delay path. The bits are assigned as follows: 0 is the dedicated vertical pin, 1 is the composite-derived sync, 2 to 4 are sync-on-green channels 0 to 2, and 5 is the alternate sync-on-green. The reset code is 0.
- R2: When `invert` is 1, the selected candidate is complemented before the delay.
- R3: Select codes 6 and 7 are reserved. The delay path then sees a constant low level whatever `invert` is, so `vs_out` settles at 0.
- R4: With a delay D between 1 and 4095, `vs_out` after clock edge n equals the polarity-adjusted selected sample taken at edge n−D. Rising and falling edges are treated alike. At any other edge `vs_out` keeps its value.
- R5: With a delay of 0, `vs_out` after edge n equals the polarity-adjusted selected sample taken at edge n.
- R6: At most 4 transitions can be pending. A transition that arrives while 4 are pending at the start of its cycle is discarded and never reaches `vs_out`.
- R7: At an edge where `src_sel` differs from the code seen at the previous edge, all pending transitions are discarded and `vs_out` holds. From the next edge on, the new source is compared with the last level that was tracked.
- R8: During reset `vs_out` is 0, nothing is pending and the tracked select code is 0.
- R9: The largest delay, 4095, reproduces a pulse with both edges exactly 4095 clocks late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_vs | input | 6 | Candidate vertical syncs, indexed by select code |
| src_sel | input | 3 | Source select code |
| invert | input | 1 | Polarity inversion of the selected sync |
| delay | input | 12 | Delay in clocks, 0 means one register stage |
| vs_out | output | 1 | Filtered and delayed vertical sync |

## Verification
The bench builds the block with its default parameters: six sources behind a 3-bit code, a queue depth of four and a 12-bit delay. With six sources, codes 6 and 7 are left reserved and can be driven directly. With a depth of four, a short burst of fast toggles under a 50-clock delay overflows the queue and exercises the drop rule. With a 12-bit delay, the full 4095-clock maximum fits in one run, so both edges of a pulse are checked at the extreme. A behavioural queue model predicts `vs_out` on every clock across source switches, polarity flips and select changes made while transitions are in flight.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
   localparam int unsigned VSD_NUM_SRC = 6;
   localparam int unsigned VSD_SEL_W   = 3;
   localparam int unsigned VSD_DLY_W   = 12;
   localparam int unsigned VSD_DEPTH   = 4;

   typedef enum logic [VSD_SEL_W-1:0] {
      SRC_VPIN  = 3'd0,
      SRC_CSYNC = 3'd1,
      SRC_SOG0  = 3'd2,
      SRC_SOG1  = 3'd3,
      SRC_SOG2  = 3'd4,
      SRC_ALT   = 3'd5
   } vsd_src_e;
endpackage

// File: rtl/vsd_src_mux.sv
module vsd_src_mux #(
   parameter int unsigned NUM_SRC = vsd_pkg::VSD_NUM_SRC,
   parameter int unsigned SEL_W   = vsd_pkg::VSD_SEL_W
) (
   input  logic [NUM_SRC-1:0] cand,
   input  logic [SEL_W-1:0]   sel,
   input  logic               invert,
   output logic               level,
   output logic               reserved
);
   localparam int unsigned CODES = 2 ** SEL_W;

   if (NUM_SRC < 1 || NUM_SRC > CODES) begin : g_bad_src
      $error("vsd_src_mux: NUM_SRC must be 1..2**SEL_W");
   end

   logic [CODES-1:0] ext;

   // Codes without a source read as constant low.
   for (genvar c = 0; c < CODES; c++) begin : g_code
      if (c < NUM_SRC) begin : g_live
         assign ext[c] = cand[c];
      end else begin : g_resv
         assign ext[c] = 1'b0;
      end
   end

   assign reserved = (int'(sel) >= int'(NUM_SRC));
   assign level    = reserved ? 1'b0 : (ext[sel] ^ invert);
endmodule

// File: rtl/vsd_edge_queue.sv
module vsd_edge_queue #(
   parameter int unsigned DEPTH = vsd_pkg::VSD_DEPTH,
   parameter int unsigned TW    = vsd_pkg::VSD_DLY_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic          push_lvl,
   input  logic [TW-1:0] delay,
   output logic          pop,
   output logic          pop_lvl
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("vsd_edge_queue: DEPTH must be at least 1");
   end
   if (TW < 1) begin : g_bad_tw
      $error("vsd_edge_queue: TW must be at least 1");
   end

   logic [TW-1:0]    now_q;
   logic [TW-1:0]    due_q   [DEPTH];
   logic [TW-1:0]    due_nx  [DEPTH];
   logic [DEPTH-1:0] lvl_q, lvl_nx;
   logic [CW-1:0]    cnt_q, widx;
   logic             accept;

   assign pop     = (cnt_q != '0) && (due_q[0] == now_q) && !clear;
   assign pop_lvl = lvl_q[0];
   assign accept  = push && !clear && (cnt_q < CW'(DEPTH));
   assign widx    = cnt_q - CW'(pop);

   always_comb begin
      for (int i = 0; i < int'(DEPTH); i++) begin
         due_nx[i] = due_q[i];
         lvl_nx[i] = lvl_q[i];
         if (pop) begin
            due_nx[i] = (i < int'(DEPTH) - 1) ? due_q[(i < int'(DEPTH) - 1) ? i + 1 : i] : due_q[i];
            lvl_nx[i] = (i < int'(DEPTH) - 1) ? lvl_q[(i < int'(DEPTH) - 1) ? i + 1 : i] : lvl_q[i];
         end
         if (accept && (CW'(i) == widx)) begin
            due_nx[i] = now_q + delay;
            lvl_nx[i] = push_lvl;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q <= '0;
         cnt_q <= '0;
         lvl_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) due_q[i] <= '0;
      end else begin
         now_q <= now_q + 1'b1;
         cnt_q <= clear ? '0 : (cnt_q - CW'(pop) + CW'(accept));
         lvl_q <= lvl_nx;
         for (int i = 0; i < int'(DEPTH); i++) due_q[i] <= due_nx[i];
      end
   end

   AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH)); // R6
   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CW'(DEPTH) && push && !pop && !clear) |=> (cnt_q == CW'(DEPTH))); // R6
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/vsync_select_delay.sv
module vsync_select_delay #(
   parameter int unsigned NUM_SRC = vsd_pkg::VSD_NUM_SRC,
   parameter int unsigned SEL_W   = vsd_pkg::VSD_SEL_W,
   parameter int unsigned DLY_W   = vsd_pkg::VSD_DLY_W,
   parameter int unsigned DEPTH   = vsd_pkg::VSD_DEPTH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] cand_vs,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic               invert,
   input  logic [DLY_W-1:0]   delay,
   output logic               vs_out
);
   logic             level, reserved;
   logic [SEL_W-1:0] sel_q;
   logic             last_q;
   logic             sel_chg, dly_zero, push, clear, pop, pop_lvl;

   vsd_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .cand     (cand_vs),
      .sel      (src_sel),
      .invert   (invert),
      .level    (level),
      .reserved (reserved)
   );

   assign sel_chg  = (src_sel != sel_q);
   assign dly_zero = (delay == '0);
   assign clear    = sel_chg || dly_zero;
   assign push     = !clear && (level != last_q);

   vsd_edge_queue #(.DEPTH(DEPTH), .TW(DLY_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .push     (push),
      .push_lvl (level),
      .delay    (delay),
      .pop      (pop),
      .pop_lvl  (pop_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         last_q <= 1'b0;
         vs_out <= 1'b0;
      end else begin
         sel_q <= src_sel;
         if (!sel_chg) begin
            last_q <= level;
            if (dly_zero)  vs_out <= level;
            else if (pop)  vs_out <= pop_lvl;
         end
      end
   end

   AST_RESERVED_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (reserved && dly_zero && !sel_chg) |=> !vs_out); // R3
   AST_ZERO_DELAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_zero && !sel_chg) |=> (vs_out == $past(level))); // R5
   AST_HOLD_UNTIL_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dly_zero && !pop) |=> $stable(vs_out)); // R4
   AST_SELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sel_chg |=> $stable(vs_out)); // R7
endmodule

// File: tb/tb_vsync_select_delay.sv
module tb_vsync_select_delay;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] cand = '0;
   logic [2:0] sel = '0;
   logic       inv = 1'b0;
   logic [11:0] dly = 12'd3;
   logic       vs_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag = "R8";

   typedef struct { int due; bit lvl; } ev_t;
   ev_t q[$];
   int  cyc = 0;
   bit  sel_m_valid;
   logic [2:0] sel_m = '0;
   bit  last_m = 1'b0;
   bit  out_m = 1'b0;
   bit  started = 1'b0;

   always #10 clk = ~clk;

   vsync_select_delay dut (
      .clk(clk), .rst_n(rst_n), .cand_vs(cand), .src_sel(sel),
      .invert(inv), .delay(dly), .vs_out(vs_out)
   );

   // Behavioural reference: transitions become timestamped events in a queue.
   always @(posedge clk) begin
      bit x;
      x = (sel < 3'd6) ? (cand[sel] ^ inv) : 1'b0;
      started <= 1'b1;
      if (!rst_n) begin
         q.delete(); sel_m = '0; last_m = 1'b0; out_m = 1'b0; cyc = 0;
      end else begin
         if (sel != sel_m) begin
            q.delete();
            sel_m = sel;
         end else if (dly == 0) begin
            q.delete();
            out_m = x;
            last_m = x;
         end else begin
            int size0;
            size0 = q.size();
            if (size0 > 0 && q[0].due == cyc) begin
               out_m = q[0].lvl;
               void'(q.pop_front());
            end
            if (x != last_m && size0 < 4) q.push_back('{cyc + int'(dly), x});
            last_m = x;
         end
         cyc++;
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (vs_out !== out_m) begin
            errors++;
            $display("FAIL %s cycle %0d: vs_out=%b expected %b", tag, cyc, vs_out, out_m);
         end
      end
   end

   task automatic run(input int n, input int p, input logic [5:0] mask);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         for (int b = 0; b < 6; b++)
            if (mask[b] && ($urandom % p) == 0) cand[b] = ~cand[b];
      end
   endtask

   task automatic set_delay(input logic [11:0] v);
      @(negedge clk); dly = 12'd0;
      @(negedge clk); dly = v;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      finish_run();
   end

   initial begin
      // R8: reset state
      tag = "R8";
      repeat (3) @(negedge clk);
      checks++;
      if (vs_out !== 1'b0) begin
         errors++; $display("FAIL R8 reset: vs_out=%b expected 0", vs_out);
      end
      rst_n = 1'b1;
      // R1: each source routed by its code
      tag = "R1";
      for (int s = 0; s < 6; s++) begin
         @(negedge clk); sel = 3'(s);
         run(60, 6, 6'h3f);
      end
      // R2: polarity flip
      tag = "R2";
      @(negedge clk); inv = 1'b1; sel = 3'd2;
      run(80, 6, 6'h3f);
      @(negedge clk); sel = 3'd5;
      run(60, 6, 6'h3f);
      // R3: reserved codes give inactive level
      tag = "R3";
      @(negedge clk); sel = 3'd6;
      run(30, 4, 6'h3f);
      @(negedge clk); inv = 1'b0;
      run(20, 4, 6'h3f);
      @(negedge clk); sel = 3'd7; inv = 1'b1;
      run(30, 4, 6'h3f);
      @(negedge clk); checks++;
      if (vs_out !== 1'b0) begin
         errors++; $display("FAIL R3 reserved: vs_out=%b expected 0", vs_out);
      end
      // R5: zero delay
      tag = "R5";
      @(negedge clk); sel = 3'd1; inv = 1'b0;
      set_delay(12'd0);
      run(60, 3, 6'h3f);
      // R4: exact delays on both edges
      tag = "R4";
      set_delay(12'd1);
      run(60, 5, 6'h3f);
      set_delay(12'd37);
      run(200, 20, 6'h3f);
      // R6: overflow of pending transitions
      tag = "R6";
      @(negedge clk); sel = 3'd0;
      set_delay(12'd50);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); cand[0] = ~cand[0];
         @(negedge clk);
         @(negedge clk);
      end
      run(80, 1000000, 6'h00);
      // R7: select change while transitions are pending
      tag = "R7";
      set_delay(12'd20);
      @(negedge clk); sel = 3'd1;
      run(15, 4, 6'h3f);
      @(negedge clk); sel = 3'd3;
      run(60, 8, 6'h3f);
      @(negedge clk); sel = 3'd4;
      run(5, 3, 6'h3f);
      @(negedge clk); sel = 3'd2;
      run(60, 1000000, 6'h00);
      // R9: largest delay
      tag = "R9";
      @(negedge clk); sel = 3'd0; inv = 1'b0; cand = '0;
      set_delay(12'd4095);
      run(5, 1000000, 6'h00);
      @(negedge clk); cand[0] = 1'b1;
      repeat (10) @(negedge clk);
      cand[0] = 1'b0;
      run(4200, 1000000, 6'h00);
      finish_run();
   end
endmodule